// File: doc/BRIEF.md
# Serial Management Frame Slave

This block is the target end of a two-wire serial management link of the clause-22 kind. A host toggles a management clock and presents one data bit per clock; the block samples the data line on each rising edge of that clock, recognises the frame start, decodes the operation and the addresses, and turns the frame into a single access on a simple parallel register port that serves 32 registers of 16 bits. On a read it returns the register value serially on the same line, with an output enable that tells the pad when to drive.

The management clock arrives as an ordinary input sampled by the system clock, so every register port strobe lasts one system clock cycle and lines up with the cycle in which a rising management clock edge is first seen. The block answers to every PHY address: the address field is decoded for framing only. The register behind the port must return read data combinationally in the strobe cycle.

Top module: `mdio_slave`

## Requirements
- R1: After a synchronous reset the block is idle, the output enable and the data output are 0, and no register strobe is issued.
- R2: While idle, a sampled 1 keeps the block idle; a sampled 0 arms start detection, further sampled 0s keep it armed, and the first sampled 1 after that begins the frame header.
- R3: The header is 12 bits sent MSB first: a 2-bit opcode, then a 5-bit PHY address that is ignored, then a 5-bit register address.
- R4: With opcode 2'b10 the block issues exactly one read strobe (write flag 0) in the cycle of the rising edge that carries the last header bit, with the register address from the header.
- R5: After that read strobe the block drives the line (output enable 1, data 0) for exactly one management clock period.
- R6: The read value is then presented MSB first, one bit per rising edge, for 16 periods; on the next rising edge the block releases the line and returns to idle.
- R7: With opcode 2'b01 the block ignores the next two bits, shifts in 16 data bits MSB first and issues exactly one write strobe (write flag 1) on the edge of the last data bit, carrying the header's register address and the 16 data bits.
- R8: Opcodes 2'b00 and 2'b11 return the block to idle with no strobe; the following frame is decoded normally.
- R9: The output enable is 1 only during read turnaround and read data, and the data output is 0 whenever the output enable is 0.
- R10: Every register strobe is one system clock wide and occurs only in a cycle where a rising management clock edge is detected.
- R11: A synchronous reset in the middle of a frame returns the block to idle at once: a pending write is dropped and a running read releases the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mdc | input | 1 | Management clock, already in the clk domain |
| mdioIn | input | 1 | Management data line as seen at the pad |
| mdioOut | output | 1 | Data driven on the line during reads |
| mdioOe | output | 1 | Drive enable for the line |
| regStrobe | output | 1 | One-cycle register access strobe |
| regWrite | output | 1 | 1 for a write access, 0 for a read access |
| regAddr | output | 5 | Register address of the access |
| regWdata | output | 16 | Write data, valid with a write strobe |
| regRdata | input | 16 | Read data, valid combinationally in the strobe cycle |

## Verification
The assertions assume that the management clock and data inputs are already synchronous to the system clock, that each management clock level lasts at least one system clock cycle, and that the register port answers a read in the same cycle. The stimulus holds every data bit steady around each management clock rising edge, keeps each clock level for two system cycles, and drives only 1s between frames and after aborted frames so that no unintended start is seen. The bench's register model is a combinational array read, matching the same-cycle rule.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HDR,
    ST_TA_RD,
    ST_TA_WR,
    ST_RD_DATA,
    ST_WR_DATA
  } mgmtState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrAcc;
    logic shiftIn;
    logic loadRead;
    logic shiftOut;
    logic latchAddr;
    logic driveLine;
    logic driveData;
  } dpCtrl_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mdio_slave_edge.sv
module mdio_slave_edge (
  input  logic clk,
  input  logic rst,
  input  logic mdc,
  output logic mdcRise
);

  logic mdcQ;

  // held high in reset so a clock already high is not taken as an edge
  always_ff @(posedge clk) begin
    if (rst) mdcQ <= 1'b1;
    else     mdcQ <= mdc;
  end

  assign mdcRise = mdc & ~mdcQ;

endmodule

// File: rtl/mdio_slave_ctrl.sv
module mdio_slave_ctrl
  import mdio_slave_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PHY_ADDR_W = 5,
  parameter int REG_ADDR_W = 5,
  parameter int OP_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdcRise,
  input  logic              mdioIn,
  input  logic [DATA_W-1:0] accNext,
  output dpCtrl_t           ctl,
  output logic              regStrobe,
  output logic              regWrite
);

  localparam int HDR_W  = OP_W + PHY_ADDR_W + REG_ADDR_W;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int TA_WR_BITS = 2;

  mgmtState_t       state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [OP_W-1:0]  opcode;
  logic             lastCount;

  assign opcode    = accNext[HDR_W-1 -: OP_W];
  assign lastCount = (cnt == CNT_W'(1));

  always_comb begin
    stateNext     = state;
    cntNext       = cnt;
    ctl           = '0;
    regStrobe     = 1'b0;
    regWrite      = 1'b0;
    ctl.driveLine = (state == ST_TA_RD) || (state == ST_RD_DATA);
    ctl.driveData = (state == ST_RD_DATA);
    if (mdcRise) begin
      unique case (state)
        ST_IDLE: begin
          if (!mdioIn) stateNext = ST_START;
        end
        ST_START: begin
          if (mdioIn) begin
            stateNext  = ST_HDR;
            cntNext    = CNT_W'(HDR_W);
            ctl.clrAcc = 1'b1;
          end
        end
        ST_HDR: begin
          ctl.shiftIn = 1'b1;
          cntNext     = cnt - CNT_W'(1);
          if (lastCount) begin
            if (opcode == OP_READ) begin
              ctl.shiftIn  = 1'b0;
              ctl.loadRead = 1'b1;
              regStrobe    = 1'b1;
              stateNext    = ST_TA_RD;
              cntNext      = CNT_W'(1);
            end else if (opcode == OP_WRITE) begin
              ctl.latchAddr = 1'b1;
              stateNext     = ST_TA_WR;
              cntNext       = CNT_W'(TA_WR_BITS);
            end else begin
              stateNext = ST_IDLE;
              cntNext   = '0;
            end
          end
        end
        ST_TA_RD: begin
          stateNext = ST_RD_DATA;
          cntNext   = CNT_W'(DATA_W);
        end
        ST_RD_DATA: begin
          if (lastCount) begin
            stateNext = ST_IDLE;
            cntNext   = '0;
          end else begin
            ctl.shiftOut = 1'b1;
            cntNext      = cnt - CNT_W'(1);
          end
        end
        ST_TA_WR: begin
          if (lastCount) begin
            stateNext = ST_WR_DATA;
            cntNext   = CNT_W'(DATA_W);
          end else begin
            cntNext = cnt - CNT_W'(1);
          end
        end
        ST_WR_DATA: begin
          ctl.shiftIn = 1'b1;
          cntNext     = cnt - CNT_W'(1);
          if (lastCount) begin
            regStrobe = 1'b1;
            regWrite  = 1'b1;
            stateNext = ST_IDLE;
          end
        end
        default: begin
          stateNext = ST_IDLE;
          cntNext   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  // counted states never sit on an exhausted counter
  assert_cnt_live_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR || state == ST_RD_DATA || state == ST_TA_WR || state == ST_WR_DATA)
      |-> (cnt != '0));

  // turnaround lasts one management clock period
  assert_ta_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TA_RD && mdcRise) |=> (state == ST_RD_DATA));

  // the write strobe closes the frame
  assert_write_ends_frame_R7: assert property (@(posedge clk) disable iff (rst)
    (regStrobe && regWrite) |=> (state == ST_IDLE));

endmodule

// File: rtl/mdio_slave_dpath.sv
module mdio_slave_dpath
  import mdio_slave_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int REG_ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mdioIn,
  input  dpCtrl_t               ctl,
  input  logic [DATA_W-1:0]     regRdata,
  output logic [DATA_W-1:0]     accNext,
  output logic [REG_ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0]     regWdata,
  output logic                  mdioOut,
  output logic                  mdioOe
);

  logic [DATA_W-1:0]     acc;
  logic [REG_ADDR_W-1:0] addrQ;

  assign accNext = {acc[DATA_W-2:0], mdioIn};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      addrQ <= '0;
    end else begin
      if (ctl.clrAcc)        acc <= '0;
      else if (ctl.loadRead) acc <= regRdata;
      else if (ctl.shiftIn)  acc <= accNext;
      else if (ctl.shiftOut) acc <= {acc[DATA_W-2:0], 1'b0};
      if (ctl.latchAddr) addrQ <= accNext[REG_ADDR_W-1:0];
    end
  end

  // the read address is taken straight from the arriving header bit
  assign regAddr  = ctl.loadRead ? accNext[REG_ADDR_W-1:0] : addrQ;
  assign regWdata = accNext;
  assign mdioOe   = ctl.driveLine;
  assign mdioOut  = ctl.driveData ? acc[DATA_W-1] : 1'b0;

  // a loaded read value is presented unchanged during the turnaround
  assert_hold_in_ta_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl.driveLine && !ctl.driveData && !ctl.shiftOut && !ctl.loadRead) |=> $stable(acc));

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
  import mdio_slave_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PHY_ADDR_W = 5,
  parameter int REG_ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mdc,
  input  logic                  mdioIn,
  output logic                  mdioOut,
  output logic                  mdioOe,
  output logic                  regStrobe,
  output logic                  regWrite,
  output logic [REG_ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0]     regWdata,
  input  logic [DATA_W-1:0]     regRdata
);

  localparam int OP_W = 2;

  logic              mdcRise;
  logic [DATA_W-1:0] accNext;
  dpCtrl_t           ctl;

  mdio_slave_edge uEdge (
    .clk     (clk),
    .rst     (rst),
    .mdc     (mdc),
    .mdcRise (mdcRise)
  );

  mdio_slave_ctrl #(
    .DATA_W     (DATA_W),
    .PHY_ADDR_W (PHY_ADDR_W),
    .REG_ADDR_W (REG_ADDR_W),
    .OP_W       (OP_W)
  ) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .mdcRise   (mdcRise),
    .mdioIn    (mdioIn),
    .accNext   (accNext),
    .ctl       (ctl),
    .regStrobe (regStrobe),
    .regWrite  (regWrite)
  );

  mdio_slave_dpath #(
    .DATA_W     (DATA_W),
    .REG_ADDR_W (REG_ADDR_W)
  ) uDpath (
    .clk      (clk),
    .rst      (rst),
    .mdioIn   (mdioIn),
    .ctl      (ctl),
    .regRdata (regRdata),
    .accNext  (accNext),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe)
  );

  assert_strobe_on_rise_R10: assert property (@(posedge clk) disable iff (rst)
    regStrobe |-> mdcRise);

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
    regStrobe |=> !regStrobe);

  assert_release_low_R9: assert property (@(posedge clk) disable iff (rst)
    !mdioOe |-> !mdioOut);

  assert_read_then_drive_R5: assert property (@(posedge clk) disable iff (rst)
    (regStrobe && !regWrite) |=> (mdioOe && !mdioOut));

endmodule

// File: tb/mdio_slave_test.sv
module mdio_slave_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdc = 1'b0;
  logic        mdioIn = 1'b1;
  logic        mdioOut, mdioOe, regStrobe, regWrite;
  logic [4:0]  regAddr;
  logic [15:0] regWdata, regRdata;

  logic [15:0] mem [32];
  int          checks = 0;
  int          errors = 0;
  int          rdCount = 0;
  int          wrCount = 0;
  logic [4:0]  lastAddr = '0;
  logic [15:0] lastData = '0;
  logic        prevStrobe = 1'b0;
  logic        prevMdc = 1'b0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  mdio_slave uut (
    .clk(clk), .rst(rst), .mdc(mdc), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe),
    .regStrobe(regStrobe), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  // register file model: same-cycle read, write on the clock edge
  assign regRdata = mem[regAddr];
  always_ff @(posedge clk) if (regStrobe && regWrite) mem[regAddr] <= regWdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    #3;
    if (!rst && regStrobe) begin
      chk(!prevStrobe && mdc && !prevMdc, "R10 strobe width/edge",
          {prevStrobe, mdc, prevMdc}, 32'h2);
      lastAddr = regAddr;
      lastData = regWdata;
      if (regWrite) wrCount++;
      else          rdCount++;
    end
    prevStrobe = regStrobe;
    prevMdc    = mdc;
  end

  task automatic mdcBit(input logic b);
    @(negedge clk); mdioIn = b; mdc = 1'b0;
    @(negedge clk);
    @(negedge clk); mdc = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic sendHeader(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    mdcBit(1'b1); mdcBit(1'b1);
    mdcBit(1'b0); mdcBit(1'b1);
    for (int i = 1; i >= 0; i--) mdcBit(op[i]);
    for (int i = 4; i >= 0; i--) mdcBit(phy[i]);
    for (int i = 4; i >= 0; i--) mdcBit(ra[i]);
  endtask

  task automatic doWrite(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    int w0;
    w0 = wrCount;
    sendHeader(2'b01, phy, ra);
    mdcBit(1'b1); mdcBit(1'b0);
    for (int i = 15; i >= 0; i--) mdcBit(d[i]);
    chk(wrCount == w0 + 1, "R7 one write strobe", wrCount, w0 + 1);
    chk(lastAddr == ra, "R7 write address", lastAddr, ra);
    chk(lastData == d, "R7 write data", lastData, d);
    chk(!mdioOe && !mdioOut, "R9 released after write", {mdioOe, mdioOut}, 0);
  endtask

  task automatic doRead(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] exp);
    int r0;
    logic [15:0] got;
    r0 = rdCount;
    got = '0;
    sendHeader(2'b10, phy, ra);
    chk(rdCount == r0 + 1, "R4 one read strobe", rdCount, r0 + 1);
    chk(lastAddr == ra, "R4 R3 read address", lastAddr, ra);
    chk(mdioOe && !mdioOut, "R5 turnaround drives 0", {mdioOe, mdioOut}, 32'h2);
    for (int i = 15; i >= 0; i--) begin
      mdcBit(1'b1);
      if (!mdioOe) chk(1'b0, "R6 enable during data", 0, 1);
      got[i] = mdioOut;
    end
    chk(got == exp, "R6 read data", got, exp);
    mdcBit(1'b1);
    chk(!mdioOe && !mdioOut, "R6 R9 release after data", {mdioOe, mdioOut}, 0);
    chk(rdCount == r0 + 1, "R4 no extra strobe", rdCount, r0 + 1);
  endtask

  // {phy, reg, data}
  localparam logic [25:0] VEC [6] = '{
    {5'd0,  5'd0,  16'h0000},
    {5'd31, 5'd31, 16'hFFFF},
    {5'd1,  5'd5,  16'hA55A},
    {5'd12, 5'd16, 16'h8001},
    {5'd7,  5'd9,  16'h1234},
    {5'd31, 5'd2,  16'h7FFE}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w0;
    int r0;
    for (int i = 0; i < 32; i++) mem[i] = 16'h5A00 | 16'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #3;
    // R1 reset state
    chk(!mdioOe && !mdioOut && !regStrobe, "R1 reset outputs", {mdioOe, mdioOut, regStrobe}, 0);
    mdcBit(1'b1); mdcBit(1'b1);
    chk(rdCount == 0 && wrCount == 0, "R1 R2 idle on ones", rdCount + wrCount, 0);

    // R3 R4 R6 read of reset contents with a nonzero PHY address
    doRead(5'd3, 5'd7, 16'h5A07);

    // vector table: write with one PHY address, read back with another
    for (int v = 0; v < 6; v++) begin
      doWrite(VEC[v][25:21], VEC[v][20:16], VEC[v][15:0]);
      doRead(VEC[v][25:21] ^ 5'h15, VEC[v][20:16], VEC[v][15:0]);
    end

    // R2 extra zeros in start detection
    r0 = rdCount;
    mdcBit(1'b1); mdcBit(1'b0); mdcBit(1'b0); mdcBit(1'b0);
    mdcBit(1'b1);
    mdcBit(1'b1); mdcBit(1'b0);
    for (int i = 0; i < 5; i++) mdcBit(1'b0);
    for (int i = 4; i >= 0; i--) mdcBit(i == 0 ? 1'b1 : 1'b0);
    chk(rdCount == r0 + 1 && lastAddr == 5'd1, "R2 repeated start zeros", lastAddr, 1);
    for (int i = 0; i < 17; i++) mdcBit(1'b1);
    chk(!mdioOe, "R2 frame completes", mdioOe, 0);

    // R8 illegal opcodes
    w0 = wrCount; r0 = rdCount;
    sendHeader(2'b00, 5'd0, 5'd5);
    chk(!mdioOe, "R8 opcode 00 no drive", mdioOe, 0);
    for (int i = 0; i < 18; i++) mdcBit(1'b1);
    sendHeader(2'b11, 5'd0, 5'd5);
    for (int i = 0; i < 18; i++) mdcBit(1'b1);
    chk(wrCount == w0 && rdCount == r0, "R8 no strobe on illegal opcode", wrCount + rdCount, w0 + r0);
    doRead(5'd0, 5'd5, 16'hA55A);

    // R11 reset mid write
    w0 = wrCount;
    sendHeader(2'b01, 5'd0, 5'd9);
    mdcBit(1'b1); mdcBit(1'b0);
    for (int i = 0; i < 8; i++) mdcBit(1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 10; i++) mdcBit(1'b1);
    chk(wrCount == w0, "R11 write dropped", wrCount, w0);
    doRead(5'd0, 5'd9, 16'h1234);

    // R11 reset mid read
    sendHeader(2'b10, 5'd0, 5'd31);
    for (int i = 0; i < 4; i++) mdcBit(1'b1);
    chk(mdioOe, "R11 read in progress", mdioOe, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); #1;
    chk(!mdioOe && !mdioOut, "R11 R1 line released by reset", {mdioOe, mdioOut}, 0);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) mdcBit(1'b1);
    doRead(5'd31, 5'd31, 16'hFFFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule